// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the host-visible register set for a two-channel storage bus-master DMA controller. It decodes byte-addressed host accesses inside a 16-byte I/O window. Each channel owns an 8-byte slice of that window. The slice holds a command byte, a status byte and a 32-bit descriptor-table pointer.

The host reads and writes these registers. A separate transfer engine sees the command fields as plain levels, along with a one-cycle start strobe, the status flags and the pointer. The engine reports errors and interrupts through one-cycle set pulses. It also drives the channel-active level, which the status byte only mirrors.

The status byte combines three write behaviours. Two bits are plain storage, two bits are write-one-to-clear flags, and one bit is read-only. The command/status half of each slice accepts single-byte accesses only.

Top module: `bm_dma_regs`

## Requirements
- R1: After reset, in both channels, the command byte, the status flags, the status storage bits and the pointer all read 0. The outputs `start_o`, `dir_o`, `start_pulse_o`, `err_flag_o`, `irq_flag_o` and `prd_addr_o` are 0.
- R2: Address bits [3] select the channel, so channel n occupies bytes 8n to 8n+7. Within a channel, offset 0 is the command byte, offset 2 is the status byte and offsets 4 to 7 are the pointer. `size_i` encodes the access width: 0 is a byte, 1 is a halfword and 2 is a word. Read data appears on `rdata_o`, low-justified and zero-extended, with `rvalid_o` high in the cycle after the request, exactly once per read.
- R3: A byte read at offset 1 or 3 returns 0xFF. A byte write to offset 1 or 3 changes no register.
- R4: At offsets 0 to 3, a halfword read returns 0xFFFF and a word read returns 0xFFFFFFFF. A non-byte write at these offsets is ignored.
- R5: A status write loads bits 6:5 from the written byte. Status bit 0 always reflects `active_i` of that channel. Status bits 7, 4 and 3 read 0.
- R6: Status bit 1 (error) and status bit 2 (interrupt) clear where a status write carries a 1 in that bit. They hold where the write carries a 0, and they hold when no write occurs.
- R7: A one-cycle `err_set_i` or `irq_set_i` pulse sets status bit 1 or bit 2, respectively, in the next cycle. If a host clear of the same bit occurs in the same cycle, the set wins.
- R8: A command write stores the whole byte. In the following cycle, `start_o` shows command bit 0 and `dir_o` shows command bit 3.
- R9: `start_pulse_o` is high for exactly one cycle, in the cycle after a command write that takes bit 0 from 0 to 1. A write that leaves bit 0 at 1 gives no pulse.
- R10: The pointer accepts byte, halfword and word writes. Each write updates only the addressed bytes, with the data taken from the low end of `wdata_i`. Pointer bits 1:0 always read 0. `prd_addr_o` exports each channel's pointer in 32-bit slices, channel 0 lowest.
- R11: Accesses and engine pulses addressed to one channel leave the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address inside the window |
| size_i | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data, low-justified |
| rdata_o | output | 32 | Read data, low-justified |
| rvalid_o | output | 1 | Read data valid |
| active_i | input | 2 | Per-channel active level from the engine |
| err_set_i | input | 2 | Per-channel error set pulse |
| irq_set_i | input | 2 | Per-channel interrupt set pulse |
| start_o | output | 2 | Per-channel command bit 0 |
| dir_o | output | 2 | Per-channel command bit 3 |
| start_pulse_o | output | 2 | One-cycle strobe on a 0-to-1 change of command bit 0 |
| err_flag_o | output | 2 | Per-channel status bit 1 |
| irq_flag_o | output | 2 | Per-channel status bit 2 |
| prd_addr_o | output | 64 | Per-channel pointer, 32 bits each |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Read data and `rvalid_o` come one edge after the read request. Command levels, the start strobe, the flags and the pointer change one edge after the write or engine pulse. The bench drives inputs on the falling edge. It expects each read item on the next falling edge, as queued by the driver. It samples the level outputs on the falling edge that follows the stimulus, and for the start strobe it samples one more falling edge to confirm that the strobe has dropped.

// File: rtl/bm_dma_pkg.sv
`timescale 1ns/1ps
package bm_dma_pkg;
  localparam int unsigned HOST_W  = 32;
  localparam int unsigned CH_SPAN = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  function automatic logic [HOST_W-1:0] size_mask(logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] size_lanes(logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_lanes = 4'b0001;
      SZ_HALF: size_lanes = 4'b0011;
      default: size_lanes = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/bm_dma_decode.sv
`timescale 1ns/1ps
module bm_dma_decode #(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned ADDR_W = $clog2(NUM_CH * bm_dma_pkg::CH_SPAN),
  localparam int unsigned CH_W   = ADDR_W - 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] ch_sel_o,
  output logic [2:0]        off_o,
  output logic              wr_o,
  output logic              rd_o
);
  assign off_o = addr_i[2:0];
  assign wr_o  = req_i & we_i;
  assign rd_o  = req_i & ~we_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_sel_o[c] = req_i && (addr_i[ADDR_W-1:3] == CH_W'(c));
  end
endmodule

// File: rtl/bm_dma_channel.sv
`timescale 1ns/1ps
module bm_dma_channel
  import bm_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [2:0]        off_i,
  input  logic [1:0]        size_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  logic              active_i,
  input  logic              err_set_i,
  input  logic              irq_set_i,
  output logic              start_o,
  output logic              dir_o,
  output logic              start_pulse_o,
  output logic              err_o,
  output logic              irq_o,
  output logic [HOST_W-1:0] addr_o,
  output logic [HOST_W-1:0] rdata_o
);
  logic [7:0]        cmd_q;
  logic [1:0]        keep_q;
  logic              err_q, irq_q, pulse_q;
  logic [HOST_W-1:0] addr_q, addr_d, wdata_sh;
  logic [3:0]        lane_en;
  logic              byte_wr, cmd_we, st_we;
  logic [7:0]        status;

  // command/status half takes byte writes only
  assign byte_wr = sel_i & wr_i & (size_i == SZ_BYTE) & ~off_i[2];
  assign cmd_we  = byte_wr & (off_i[1:0] == 2'd0);
  assign st_we   = byte_wr & (off_i[1:0] == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= cmd_we & wdata_i[0] & ~cmd_q[0];
      if (cmd_we) cmd_q <= wdata_i[7:0];
    end
  end

  // engine set has priority over host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= '0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (st_we) keep_q <= wdata_i[6:5];
      err_q <= err_set_i | (err_q & ~(st_we & wdata_i[1]));
      irq_q <= irq_set_i | (irq_q & ~(st_we & wdata_i[2]));
    end
  end

  assign status = {1'b0, keep_q, 2'b00, irq_q, err_q, active_i};

  assign lane_en  = (sel_i & wr_i & off_i[2]) ? (size_lanes(size_i) << off_i[1:0]) : 4'b0000;
  assign wdata_sh = wdata_i << {off_i[1:0], 3'b000};

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign addr_d[8*k +: 8] = lane_en[k] ? wdata_sh[8*k +: 8] : addr_q[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= {addr_d[HOST_W-1:2], 2'b00};
  end

  always_comb begin
    if (off_i[2]) begin
      rdata_o = (addr_q >> {off_i[1:0], 3'b000}) & size_mask(size_i);
    end else if (size_i != SZ_BYTE) begin
      rdata_o = size_mask(size_i);
    end else begin
      case (off_i[1:0])
        2'd0:    rdata_o = {24'h0, cmd_q};
        2'd2:    rdata_o = {24'h0, status};
        default: rdata_o = 32'h0000_00FF;
      endcase
    end
  end

  assign start_o       = cmd_q[0];
  assign dir_o         = cmd_q[3];
  assign start_pulse_o = pulse_q;
  assign err_o         = err_q;
  assign irq_o         = irq_q;
  assign addr_o        = addr_q;
endmodule

// File: rtl/bm_dma_rsp.sv
`timescale 1ns/1ps
module bm_dma_rsp
  import bm_dma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic [NUM_CH-1:0]        ch_sel_i,
  input  logic [NUM_CH*HOST_W-1:0] ch_rdata_i,
  output logic [HOST_W-1:0]        rdata_o,
  output logic                     rvalid_o
);
  logic [HOST_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel_i[c]) rdata_d = rdata_d | ch_rdata_i[c*HOST_W +: HOST_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/bm_dma_regs.sv
`timescale 1ns/1ps
module bm_dma_regs
  import bm_dma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned ADDR_W = $clog2(NUM_CH * CH_SPAN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [1:0]               size_i,
  input  logic [HOST_W-1:0]        wdata_i,
  output logic [HOST_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  input  logic [NUM_CH-1:0]        active_i,
  input  logic [NUM_CH-1:0]        err_set_i,
  input  logic [NUM_CH-1:0]        irq_set_i,
  output logic [NUM_CH-1:0]        start_o,
  output logic [NUM_CH-1:0]        dir_o,
  output logic [NUM_CH-1:0]        start_pulse_o,
  output logic [NUM_CH-1:0]        err_flag_o,
  output logic [NUM_CH-1:0]        irq_flag_o,
  output logic [NUM_CH*HOST_W-1:0] prd_addr_o
);
  logic [NUM_CH-1:0]        ch_sel;
  logic [2:0]               off;
  logic                     wr, rd;
  logic [NUM_CH*HOST_W-1:0] ch_rdata;

  bm_dma_decode #(.NUM_CH(NUM_CH)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .ch_sel_o(ch_sel),
    .off_o   (off),
    .wr_o    (wr),
    .rd_o    (rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bm_dma_channel u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (ch_sel[c]),
      .wr_i         (wr),
      .off_i        (off),
      .size_i       (size_i),
      .wdata_i      (wdata_i),
      .active_i     (active_i[c]),
      .err_set_i    (err_set_i[c]),
      .irq_set_i    (irq_set_i[c]),
      .start_o      (start_o[c]),
      .dir_o        (dir_o[c]),
      .start_pulse_o(start_pulse_o[c]),
      .err_o        (err_flag_o[c]),
      .irq_o        (irq_flag_o[c]),
      .addr_o       (prd_addr_o[c*HOST_W +: HOST_W]),
      .rdata_o      (ch_rdata[c*HOST_W +: HOST_W])
    );
  end

  bm_dma_rsp #(.NUM_CH(NUM_CH)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd),
    .ch_sel_i  (ch_sel),
    .ch_rdata_i(ch_rdata),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );
endmodule

// File: rtl/bm_dma_regs_chk.sv
`timescale 1ns/1ps
module bm_dma_regs_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              rvalid_o,
  input logic [NUM_CH-1:0] err_set_i,
  input logic [NUM_CH-1:0] irq_set_i,
  input logic [NUM_CH-1:0] start_o,
  input logic [NUM_CH-1:0] dir_o,
  input logic [NUM_CH-1:0] start_pulse_o,
  input logic [NUM_CH-1:0] err_flag_o,
  input logic [NUM_CH-1:0] irq_flag_o
);
  p_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  p_rvalid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_err_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_set_i[c] |=> err_flag_o[c]);
    p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_set_i[c] |=> irq_flag_o[c]);
    p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_flag_o[c] && !req_i) |=> err_flag_o[c]);
    p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_flag_o[c] && !req_i) |=> irq_flag_o[c]);
    p_pulse_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_pulse_o[c] |-> (start_o[c] && !$past(start_o[c])));
    p_cmd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> ($stable(start_o[c]) && $stable(dir_o[c])));
  end
endmodule

bind bm_dma_regs bm_dma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .rvalid_o     (rvalid_o),
  .err_set_i    (err_set_i),
  .irq_set_i    (irq_set_i),
  .start_o      (start_o),
  .dir_o        (dir_o),
  .start_pulse_o(start_pulse_o),
  .err_flag_o   (err_flag_o),
  .irq_flag_o   (irq_flag_o)
);

// File: tb/tb_bm_dma_regs.sv
`timescale 1ns/1ps
module tb_bm_dma_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  active = '0, err_set = '0, irq_set = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [1:0]  start_o, dir_o, start_pulse_o, err_flag_o, irq_flag_o;
  logic [63:0] prd_addr_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bm_dma_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .active_i(active), .err_set_i(err_set), .irq_set_i(irq_set),
    .start_o(start_o), .dir_o(dir_o), .start_pulse_o(start_pulse_o),
    .err_flag_o(err_flag_o), .irq_flag_o(irq_flag_o), .prd_addr_o(prd_addr_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] s, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic engine(int ch, bit e, bit i);
    @(negedge clk);
    err_set[ch] = e; irq_set[ch] = i;
    @(negedge clk);
    err_set = '0; irq_set = '0;
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rvalid_o) begin
      if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 start_o", {30'h0, start_o}, 32'h0);
    check("R1 flags", {28'h0, err_flag_o, irq_flag_o}, 32'h0);
    check("R1 prd_addr_o lo", prd_addr_o[31:0], 32'h0);
    check("R1 prd_addr_o hi", prd_addr_o[63:32], 32'h0);
    rd(4'd0, 2'd0, 32'h00, "R1 ch0 cmd");
    rd(4'd2, 2'd0, 32'h00, "R1 ch0 status");
    rd(4'd12, 2'd2, 32'h0, "R1 ch1 pointer");

    // R5 active mirror and storage bits
    active[0] = 1'b1;
    rd(4'd2, 2'd0, 32'h01, "R5 active mirror");
    wr(4'd2, 2'd0, 32'hFF);
    rd(4'd2, 2'd0, 32'h61, "R5 status after 0xFF");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h01, "R5 status after 0x00");

    // R7 engine sets, R6 W1C
    engine(0, 1'b1, 1'b1);
    check("R7 err_flag_o", {31'h0, err_flag_o[0]}, 32'h1);
    check("R7 irq_flag_o", {31'h0, irq_flag_o[0]}, 32'h1);
    rd(4'd2, 2'd0, 32'h07, "R7 status after sets");
    wr(4'd2, 2'd0, 32'h02);
    rd(4'd2, 2'd0, 32'h05, "R6 clear err only");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h05, "R6 zero write holds");
    wr(4'd2, 2'd0, 32'h04);
    rd(4'd2, 2'd0, 32'h01, "R6 clear irq");

    // R7 set beats same-cycle clear
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 4'd2; size = 2'd0; wdata = 32'h02; err_set[0] = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; err_set = '0;
    rd(4'd2, 2'd0, 32'h03, "R7 set wins over clear");
    wr(4'd2, 2'd0, 32'h02);

    // R8 / R9 command and start strobe
    wr(4'd0, 2'd0, 32'h09);
    check("R8 start_o", {31'h0, start_o[0]}, 32'h1);
    check("R8 dir_o", {31'h0, dir_o[0]}, 32'h1);
    check("R9 pulse high", {30'h0, start_pulse_o}, 32'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {30'h0, start_pulse_o}, 32'h0);
    rd(4'd0, 2'd0, 32'h09, "R8 cmd readback");
    wr(4'd0, 2'd0, 32'h09);
    check("R9 no pulse when already set", {30'h0, start_pulse_o}, 32'h0);
    wr(4'd0, 2'd0, 32'h08);
    check("R8 start_o cleared", {31'h0, start_o[0]}, 32'h0);
    check("R8 dir_o kept", {31'h0, dir_o[0]}, 32'h1);

    // R3 gap offsets
    rd(4'd1, 2'd0, 32'hFF, "R3 offset 1 read");
    rd(4'd3, 2'd0, 32'hFF, "R3 offset 3 read");
    wr(4'd1, 2'd0, 32'h55);
    wr(4'd3, 2'd0, 32'h66);
    rd(4'd0, 2'd0, 32'h08, "R3 cmd untouched");
    rd(4'd2, 2'd0, 32'h01, "R3 status untouched");

    // R4 non-byte accesses
    rd(4'd0, 2'd1, 32'h0000FFFF, "R4 halfword read");
    rd(4'd2, 2'd2, 32'hFFFFFFFF, "R4 word read");
    wr(4'd0, 2'd1, 32'h0001);
    check("R4 halfword write ignored start_o", {31'h0, start_o[0]}, 32'h0);
    wr(4'd2, 2'd1, 32'h0060);
    wr(4'd0, 2'd2, 32'h0000_6001);
    rd(4'd0, 2'd0, 32'h08, "R4 cmd unchanged");
    rd(4'd2, 2'd0, 32'h01, "R4 status unchanged");

    // R10 pointer lanes, channel 1
    wr(4'd12, 2'd2, 32'h12345677);
    check("R10 prd_addr_o word", prd_addr_o[63:32], 32'h12345674);
    rd(4'd12, 2'd2, 32'h12345674, "R10 word readback");
    wr(4'd15, 2'd0, 32'hAB);
    rd(4'd12, 2'd2, 32'hAB345674, "R10 byte lane 3");
    wr(4'd12, 2'd1, 32'hBEEF);
    check("R10 prd_addr_o half", prd_addr_o[63:32], 32'hAB34BEEC);
    rd(4'd13, 2'd0, 32'hBE, "R10 byte read offset 5");
    rd(4'd14, 2'd1, 32'hAB34, "R10 halfword read offset 6");

    // R11 channel isolation
    rd(4'd4, 2'd2, 32'h0, "R11 ch0 pointer untouched");
    rd(4'd10, 2'd0, 32'h00, "R11 ch1 status");
    rd(4'd8, 2'd0, 32'h00, "R11 ch1 cmd");
    engine(1, 1'b1, 1'b0);
    rd(4'd2, 2'd0, 32'h01, "R11 ch0 status after ch1 pulse");
    rd(4'd10, 2'd0, 32'h02, "R11 ch1 err set");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R2 missing read responses", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule